// File: doc/BRIEF.md
# Window-Tag Guarded Pixel Writer

This block stands between one rendering engine and its frame-buffer bank. Every pixel word in the bank carries an 8-bit window tag. This tag records which window owns the pixel. The renderer sends write requests that carry a target address, the tag of the window being drawn, a color for one of two color buffers, a depth value, a transparency value and cursor overlay bits. The block reads the tag already stored at the target address and compares it with the tag in the request. The write goes ahead only when the two tags are equal. Otherwise the request is dropped without any change to memory. This lets windows of any shape clip themselves in hardware, with no clip rectangles in the renderer.

The whole address range is treated the same way, so a write to the upper half of the bank is guarded in the same way as a write to the visible area. The upper half stands for off-screen storage. A window manager can set the bypass flag on a request to skip the tag test, and in that case the request also writes a new tag. A second, read-only scan port exposes stored pixels, as a display refresh path would see them. Each cancelled request gives a one-cycle pulse on a status output.

The bank is a synchronous RAM with one cycle of read latency. Each request therefore takes two cycles: a read cycle and a compare-and-write cycle.

Top module: `wtg_guarded_writer`

## Requirements
- R1: After reset, `req_ready` is 1 and `reject_pulse` is 0.
- R2: Once a request is accepted (`req_valid` and `req_ready` both high at a clock edge), `req_ready` is 0 for the next cycle only and then returns to 1. While `req_ready` is 0, request inputs are ignored, so at most one request is accepted every two cycles.
- R3: When the request tag equals the stored tag, the write commits. Depth, transparency, cursor bits and the selected color buffer take the request values, and the stored tag stays as it was.
- R4: When the request tag differs from the stored tag and bypass is 0, no field of the stored pixel changes.
- R5: `reject_pulse` is 1 for exactly one cycle, the cycle that follows the compare cycle, and only for cancelled requests.
- R6: `req_buf_sel` = 0 writes color buffer A and `req_buf_sel` = 1 writes color buffer B. The buffer that is not selected keeps its value.
- R7: With `req_bypass` = 1 the write always commits, the stored tag becomes the request tag, and `reject_pulse` stays 0.
- R8: The guard rule is the same at every address, including the highest address and the off-screen upper half.
- R9: `scan_pixel` gives the word stored at `scan_addr` one cycle after the address is presented. The packing from the MSB down is cursor[14:0], tag[7:0], transparency[7:0], depth[23:0], color B[23:0], color A[23:0], so color A sits in bits 23:0 and the tag in bits 87:80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_addr | input | ADDR_W | Target pixel address |
| req_wid | input | 8 | Window tag of the incoming pixel |
| req_color | input | 24 | Color value for the selected buffer |
| req_buf_sel | input | 1 | 0 = color buffer A, 1 = color buffer B |
| req_depth | input | 24 | Depth value |
| req_alpha | input | 8 | Transparency value |
| req_cursor | input | 15 | Cursor overlay bits |
| req_bypass | input | 1 | Skip the tag test and write the new tag |
| reject_pulse | output | 1 | One-cycle pulse for each cancelled request |
| scan_addr | input | ADDR_W | Scan-port read address |
| scan_pixel | output | 103 | Packed stored pixel, one cycle latency |

## Verification
A wrong compare result is visible on `reject_pulse` one cycle after the compare cycle. A wrong merge shows up on the scan port as soon as the address that was written is read back, which is two cycles after acceptance. A held busy flag shows on `req_ready` in the cycle after acceptance, or a cycle later if the flag fails to clear. A write that corrupts the buffer that was not selected, or a tag that changes on a match, is caught by reading back the full word and comparing it with a bench model that keeps every address.

// File: rtl/wtg_pkg.sv
package wtg_pkg;
    localparam int WID_W    = 8;
    localparam int COLOR_W  = 24;
    localparam int DEPTH_W  = 24;
    localparam int ALPHA_W  = 8;
    localparam int CURSOR_W = 15;

    // MSB first: cursor, tag, transparency, depth, color B, color A
    typedef struct packed {
        logic [CURSOR_W-1:0] cursor;
        logic [WID_W-1:0]    wid;
        logic [ALPHA_W-1:0]  alpha;
        logic [DEPTH_W-1:0]  depth;
        logic [COLOR_W-1:0]  color_b;
        logic [COLOR_W-1:0]  color_a;
    } pixel_t;

    localparam int PIX_W = $bits(pixel_t);
endpackage

// File: rtl/wtg_pixel_ram.sv
module wtg_pixel_ram
    import wtg_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_rd_en,
    input  logic [ADDR_W-1:0] a_rd_addr,
    output pixel_t            a_rd_data,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_wr_addr,
    input  pixel_t            a_wr_data,
    input  logic [ADDR_W-1:0] b_addr,
    output pixel_t            b_data
);
    localparam int WORDS = 1 << ADDR_W;

    pixel_t mem_q [WORDS];
    pixel_t a_rd_q;
    pixel_t b_rd_q;

    always_ff @(posedge clk) begin
        if (a_we) begin
            mem_q[a_wr_addr] <= a_wr_data;
        end
        if (a_rd_en) begin
            a_rd_q <= mem_q[a_rd_addr];
        end
        b_rd_q <= mem_q[b_addr];
    end

    assign a_rd_data = a_rd_q;
    assign b_data    = b_rd_q;

    // R2: the writer never reads and writes port A in the same cycle
    a_r2_port_a_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        a_we |-> !a_rd_en);
endmodule

// File: rtl/wtg_tag_cmp.sv
module wtg_tag_cmp
    import wtg_pkg::*;
(
    input  logic [WID_W-1:0] stored_wid,
    input  logic [WID_W-1:0] incoming_wid,
    input  logic             bypass,
    output logic             allow
);
    // R3/R4/R7: equal tags or bypass permit the write
    always_comb begin
        allow = bypass || (stored_wid == incoming_wid);
    end
endmodule

// File: rtl/wtg_pixel_merge.sv
module wtg_pixel_merge
    import wtg_pkg::*;
(
    input  pixel_t              old_px,
    input  logic [WID_W-1:0]    new_wid,
    input  logic [COLOR_W-1:0]  new_color,
    input  logic                buf_sel,
    input  logic [DEPTH_W-1:0]  new_depth,
    input  logic [ALPHA_W-1:0]  new_alpha,
    input  logic [CURSOR_W-1:0] new_cursor,
    output pixel_t              merged_px
);
    // R6: only the selected color buffer is replaced
    always_comb begin
        merged_px        = old_px;
        merged_px.wid    = new_wid;
        merged_px.depth  = new_depth;
        merged_px.alpha  = new_alpha;
        merged_px.cursor = new_cursor;
        if (buf_sel) begin
            merged_px.color_b = new_color;
        end else begin
            merged_px.color_a = new_color;
        end
    end
endmodule

// File: rtl/wtg_guarded_writer.sv
module wtg_guarded_writer
    import wtg_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [WID_W-1:0]    req_wid,
    input  logic [COLOR_W-1:0]  req_color,
    input  logic                req_buf_sel,
    input  logic [DEPTH_W-1:0]  req_depth,
    input  logic [ALPHA_W-1:0]  req_alpha,
    input  logic [CURSOR_W-1:0] req_cursor,
    input  logic                req_bypass,
    output logic                reject_pulse,
    input  logic [ADDR_W-1:0]   scan_addr,
    output logic [PIX_W-1:0]    scan_pixel
);
    typedef struct packed {
        logic                busy;
        logic [ADDR_W-1:0]   addr;
        logic [WID_W-1:0]    wid;
        logic [COLOR_W-1:0]  color;
        logic                buf_sel;
        logic [DEPTH_W-1:0]  depth;
        logic [ALPHA_W-1:0]  alpha;
        logic [CURSOR_W-1:0] cursor;
        logic                bypass;
        logic                reject;
    } state_t;

    state_t st_d, st_q;

    logic   ram_rd_en;
    logic   ram_we;
    pixel_t stored_px;
    pixel_t merged_px;
    pixel_t scan_px;
    logic   allow;

    wtg_pixel_ram #(.ADDR_W(ADDR_W)) i_ram (
        .clk       (clk),
        .rst_n     (rst_n),
        .a_rd_en   (ram_rd_en),
        .a_rd_addr (req_addr),
        .a_rd_data (stored_px),
        .a_we      (ram_we),
        .a_wr_addr (st_q.addr),
        .a_wr_data (merged_px),
        .b_addr    (scan_addr),
        .b_data    (scan_px)
    );

    wtg_tag_cmp i_cmp (
        .stored_wid   (stored_px.wid),
        .incoming_wid (st_q.wid),
        .bypass       (st_q.bypass),
        .allow        (allow)
    );

    wtg_pixel_merge i_merge (
        .old_px     (stored_px),
        .new_wid    (st_q.wid),
        .new_color  (st_q.color),
        .buf_sel    (st_q.buf_sel),
        .new_depth  (st_q.depth),
        .new_alpha  (st_q.alpha),
        .new_cursor (st_q.cursor),
        .merged_px  (merged_px)
    );

    always_comb begin
        st_d        = st_q;
        st_d.reject = 1'b0;
        ram_rd_en   = 1'b0;
        ram_we      = 1'b0;
        if (!st_q.busy) begin
            if (req_valid) begin
                st_d.busy    = 1'b1;
                st_d.addr    = req_addr;
                st_d.wid     = req_wid;
                st_d.color   = req_color;
                st_d.buf_sel = req_buf_sel;
                st_d.depth   = req_depth;
                st_d.alpha   = req_alpha;
                st_d.cursor  = req_cursor;
                st_d.bypass  = req_bypass;
                ram_rd_en    = 1'b1;
            end
        end else begin
            st_d.busy = 1'b0;
            if (allow) begin
                ram_we = 1'b1;
            end else begin
                st_d.reject = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready    = !st_q.busy;
    assign reject_pulse = st_q.reject;
    assign scan_pixel   = scan_px;

    a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r2_ready_returns: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> req_ready);

    a_r5_reject_single: assert property (@(posedge clk) disable iff (!rst_n)
        reject_pulse |=> !reject_pulse);

    a_r5_reject_after_check: assert property (@(posedge clk) disable iff (!rst_n)
        reject_pulse |-> $past(!req_ready));

    a_r7_bypass_never_rejects: assert property (@(posedge clk) disable iff (!rst_n)
        reject_pulse |-> !$past(st_q.bypass));

    a_r4_no_write_with_reject: assert property (@(posedge clk) disable iff (!rst_n)
        reject_pulse |-> !$past(ram_we));
endmodule

// File: tb/test_wtg_guarded_writer.sv
`timescale 1ns/1ps
module test_wtg_guarded_writer;
    import wtg_pkg::*;

    localparam int AW    = 6;
    localparam int WORDS = 1 << AW;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                req_valid = 1'b0;
    logic                req_ready;
    logic [AW-1:0]       req_addr = '0;
    logic [WID_W-1:0]    req_wid = '0;
    logic [COLOR_W-1:0]  req_color = '0;
    logic                req_buf_sel = 1'b0;
    logic [DEPTH_W-1:0]  req_depth = '0;
    logic [ALPHA_W-1:0]  req_alpha = '0;
    logic [CURSOR_W-1:0] req_cursor = '0;
    logic                req_bypass = 1'b0;
    logic                reject_pulse;
    logic [AW-1:0]       scan_addr = '0;
    logic [PIX_W-1:0]    scan_pixel;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    pixel_t model [WORDS];

    always #10 clk = ~clk;

    wtg_guarded_writer #(.ADDR_W(AW)) i_wtg_guarded_writer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_wid(req_wid), .req_color(req_color),
        .req_buf_sel(req_buf_sel), .req_depth(req_depth), .req_alpha(req_alpha),
        .req_cursor(req_cursor), .req_bypass(req_bypass),
        .reject_pulse(reject_pulse), .scan_addr(scan_addr), .scan_pixel(scan_pixel)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic pixel_t expect_px(input pixel_t old, input logic [WID_W-1:0] w,
                                         input logic [COLOR_W-1:0] c, input logic sel,
                                         input logic [DEPTH_W-1:0] d, input logic [ALPHA_W-1:0] a,
                                         input logic [CURSOR_W-1:0] cur, input logic byp,
                                         output logic rej);
        pixel_t n = old;
        rej = !(byp || (old.wid == w));
        if (!rej) begin
            if (sel) n.color_b = c; else n.color_a = c;
            n.depth = d; n.alpha = a; n.cursor = cur; n.wid = w;
        end
        return n;
    endfunction

    // called at a negedge; returns at a negedge
    task automatic do_req(input logic [AW-1:0] a, input logic [WID_W-1:0] w,
                          input logic sel, input logic byp, input string tag);
        logic [COLOR_W-1:0]  c   = COLOR_W'($urandom);
        logic [DEPTH_W-1:0]  d   = DEPTH_W'($urandom);
        logic [ALPHA_W-1:0]  al  = ALPHA_W'($urandom);
        logic [CURSOR_W-1:0] cur = CURSOR_W'($urandom);
        logic rej;
        pixel_t exp_px = expect_px(model[a], w, c, sel, d, al, cur, byp, rej);
        req_valid = 1'b1; req_addr = a; req_wid = w; req_color = c; req_buf_sel = sel;
        req_depth = d; req_alpha = al; req_cursor = cur; req_bypass = byp;
        chk({"R2 ready before accept ", tag}, 128'(req_ready), 128'(1));
        @(posedge clk); @(negedge clk);
        chk({"R2 ready low in check cycle ", tag}, 128'(req_ready), 128'(0));
        // R2: garbage while not ready must be ignored
        req_valid = 1'($urandom); req_addr = AW'($urandom); req_wid = WID_W'($urandom);
        req_bypass = 1'($urandom);
        @(posedge clk); @(negedge clk);
        chk({"R5 reject pulse ", tag}, 128'(reject_pulse), 128'(rej));
        chk({"R2 ready back ", tag}, 128'(req_ready), 128'(1));
        req_valid = 1'b0;
        model[a] = exp_px;
    endtask

    task automatic scan_check(input logic [AW-1:0] a, input string tag);
        scan_addr = a;
        @(posedge clk); @(negedge clk);
        chk({"R9 scan word ", tag}, 128'(scan_pixel), 128'(model[a]));
    endtask

    initial begin
        void'($urandom(32'd7731));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 ready after reset", 128'(req_ready), 128'(1));
        chk("R1 reject after reset", 128'(reject_pulse), 128'(0));

        // fill every word, both buffers, via bypass (R7)
        for (int a = 0; a < WORDS; a++) begin
            do_req(AW'(a), WID_W'(a) ^ 8'h5A, 1'b0, 1'b1, "R7 init A");
            do_req(AW'(a), WID_W'(a) ^ 8'h5A, 1'b1, 1'b1, "R7 init B");
        end
        for (int a = 0; a < WORDS; a++) scan_check(AW'(a), "R9 after init");

        // directed corners
        do_req('0, model[0].wid, 1'b0, 1'b0, "R3 match addr0 buf A");
        scan_check('0, "R3 R6 addr0");
        do_req('0, model[0].wid, 1'b1, 1'b0, "R6 match addr0 buf B");
        scan_check('0, "R6 addr0 buf B");
        do_req(AW'(WORDS-1), model[WORDS-1].wid ^ 8'h01, 1'b0, 1'b0, "R8 offscreen mismatch");
        scan_check(AW'(WORDS-1), "R4 R8 top unchanged");
        do_req(AW'(WORDS-1), model[WORDS-1].wid, 1'b1, 1'b0, "R8 offscreen match");
        scan_check(AW'(WORDS-1), "R8 top written");
        do_req(AW'(5), 8'hC3, 1'b0, 1'b1, "R7 bypass retag");
        scan_check(AW'(5), "R7 new tag stored");
        do_req(AW'(5), WID_W'(5) ^ 8'h5A, 1'b1, 1'b0, "R4 old tag rejected");
        scan_check(AW'(5), "R4 word unchanged");

        // constrained random
        for (int i = 0; i < 400; i++) begin
            logic [AW-1:0]    a   = AW'($urandom);
            logic [WID_W-1:0] w   = ($urandom % 10 < 6) ? model[a].wid : WID_W'($urandom);
            logic             byp = ($urandom % 10 == 0);
            do_req(a, w, 1'($urandom), byp, "R3 R4 R6 random");
            scan_check(a, "R3 R4 R8 random readback");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule